// File: doc/BRIEF.md
# PC Card Socket Window Decoder

The decoder connects a system bus to a single removable card socket. The socket takes a 256 MB aperture, and the two most significant aperture address bits divide it into four 64 MB regions: I/O space, a reserved hole, attribute memory and common memory. An access to a live region goes to the card-side port. It carries a space code and an offset that counts from the start of its region. The access completes on the bus once the card has accepted it (writes) or has returned data (reads).

The block also keeps track of whether a card is in the socket. Insert and eject requests each run a fixed sequence. The sequence drives a card-detect interrupt, marks the socket full or empty, and pulses an attach or detach notification to the card model. A request that does not fit the current socket state is refused with an error flag. While the socket is occupied, the card's own interrupt level reaches the host only when the host has enabled its interrupt line. The bus, insert and eject inputs are held high until their completion pulse. When an event and a bus access become ready in the same cycle, the event goes first.

Top module: `pccard_window_dec`

## Requirements
- R1: Aperture address bits [27:26] select the region and appear on `crd_space` for a forwarded access. The codes are 00 for I/O, 10 for attribute memory and 11 for common memory.
- R2: A forwarded access carries `crd_off` equal to aperture address bits [25:0], which is the address minus its region base. `crd_we`, `crd_wdata` and the 2-bit size code (00 byte, 01 half, 10 word) pass through unchanged.
- R3: An access to region 01 (reserved) is never forwarded, with or without a card present. It completes with read data zero.
- R4: While the socket is empty, no access reaches the card port, reads return zero and writes are dropped.
- R5: `crd_req_valid` stays high with stable fields until a cycle with `crd_req_ready`. A write acks after acceptance. A read acks after `crd_rsp_valid`, with that cycle's `crd_rdata` on `bus_rdata` during the one-cycle `bus_ack`.
- R6: An insert while occupied, or an eject while empty, finishes on the first cycle with `evt_done` and `evt_err` high. `sock_status` stays unchanged and no attach or detach pulse is issued.
- R7: A good insert raises `cd_irq` (status bit1) one cycle before status bit0 (occupied). In the cycle where occupied first reads 1, `crd_attach` pulses. `evt_done` follows one cycle later with `evt_err` low.
- R8: A good eject pulses `crd_detach` first, clears occupied on the next cycle, and drives `cd_irq` and `host_irq` low on the cycle after that, together with `evt_done`.
- R9: While the socket is occupied and `host_irq_en` is high, `host_irq` takes the value of `card_irq` one cycle later. Otherwise `host_irq` holds its value, except for the clear in R8.
- R10: After reset, `sock_status`, `cd_irq`, `host_irq`, `bus_ack`, `crd_req_valid` and `evt_done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Aperture address |
| bus_size | input | 2 | Size code |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| crd_req_valid | output | 1 | Card request valid |
| crd_req_ready | input | 1 | Card accepts request |
| crd_we | output | 1 | Card request is a write |
| crd_space | output | 2 | Space code |
| crd_off | output | ADDR_W-2 | Region-relative offset |
| crd_size | output | 2 | Size code |
| crd_wdata | output | DATA_W | Card write data |
| crd_rsp_valid | input | 1 | Card read data valid |
| crd_rdata | input | DATA_W | Card read data |
| crd_attach | output | 1 | Attach notification pulse |
| crd_detach | output | 1 | Detach notification pulse |
| insert_req | input | 1 | Insert request, held until evt_done |
| eject_req | input | 1 | Eject request, held until evt_done |
| evt_done | output | 1 | Event completion pulse |
| evt_err | output | 1 | Event refused, valid with evt_done |
| card_irq | input | 1 | Card interrupt level |
| host_irq_en | input | 1 | Host interrupt line enabled |
| host_irq | output | 1 | Host interrupt level |
| cd_irq | output | 1 | Card-detect interrupt |
| sock_status | output | 2 | bit1 card-detect level, bit0 occupied |

## Verification
The bench probes both edges of every region, including the top word of I/O space and the last byte of attribute memory. An offset that kept the region bits, or that lost its top bit, shows up there as a wrong `crd_off`. Each vector runs on an empty socket and again on an occupied one, and the card holds off ready for a varying number of cycles. A design that forwarded reserved or empty-socket accesses, or dropped `crd_req_valid` early, would be caught. Insert and eject are sampled cycle by cycle, so swapping the card-detect rise and the occupied mark, or clearing the interrupts before occupancy drops, fails. The refused events check that the socket state is left untouched.

// File: rtl/pccard_win_pkg.sv
package pccard_win_pkg;

  typedef enum logic [1:0] {
    SPC_IO     = 2'b00,
    SPC_RSVD   = 2'b01,
    SPC_ATTR   = 2'b10,
    SPC_COMMON = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    AX_IDLE,
    AX_ISSUE,
    AX_WAIT,
    AX_DONE
  } acc_state_e;

  typedef enum logic [2:0] {
    SK_IDLE,
    SK_INS_OCC,
    SK_INS_ATT,
    SK_EJ_DET,
    SK_EJ_LOW,
    SK_DONE
  } sock_state_e;

endpackage

// File: rtl/pcwd_rst_sync.sv
module pcwd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/pcwd_decode.sv
module pcwd_decode
  import pccard_win_pkg::*;
#(
  parameter int ADDR_W = 28,
  localparam int OFF_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output space_e            space,
  output logic [OFF_W-1:0]  off,
  output logic              live
);
  // Regions are aligned to their size, so rebasing is a mask of the select bits.
  assign space = space_e'(addr[ADDR_W-1 -: 2]);
  assign off   = addr[OFF_W-1:0];
  assign live  = (space != SPC_RSVD);
endmodule

// File: rtl/pcwd_access.sv
module pcwd_access
  import pccard_win_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  localparam int OFF_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              occupied,
  input  logic              evt_block,
  output logic              acc_idle,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              crd_req_valid,
  input  logic              crd_req_ready,
  output logic              crd_we,
  output logic [1:0]        crd_space,
  output logic [OFF_W-1:0]  crd_off,
  output logic [1:0]        crd_size,
  output logic [DATA_W-1:0] crd_wdata,
  input  logic              crd_rsp_valid,
  input  logic [DATA_W-1:0] crd_rdata
);
  acc_state_e        st_q, st_d;
  space_e            dec_space;
  logic [OFF_W-1:0]  dec_off;
  logic              dec_live;
  logic              cap_en, rd_ld, accept;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              we_q;
  space_e            spc_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        sz_q;
  logic [DATA_W-1:0] wd_q;

  pcwd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr  (bus_addr),
    .space (dec_space),
    .off   (dec_off),
    .live  (dec_live)
  );

  assign accept = (st_q == AX_IDLE) && bus_req && !evt_block;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    rd_ld  = 1'b0;
    rd_d   = rd_q;
    case (st_q)
      AX_IDLE: begin
        if (accept) begin
          cap_en = 1'b1;
          rd_ld  = 1'b1;
          rd_d   = '0;
          st_d   = (dec_live && occupied) ? AX_ISSUE : AX_DONE;
        end
      end
      AX_ISSUE: begin
        if (crd_req_ready) st_d = we_q ? AX_DONE : AX_WAIT;
      end
      AX_WAIT: begin
        if (crd_rsp_valid) begin
          rd_ld = 1'b1;
          rd_d  = crd_rdata;
          st_d  = AX_DONE;
        end
      end
      AX_DONE: st_d = AX_IDLE;
      default: st_d = AX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= AX_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_ld) rd_q <= rd_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      we_q  <= bus_we;
      spc_q <= dec_space;
      off_q <= dec_off;
      sz_q  <= bus_size;
      wd_q  <= bus_wdata;
    end
  end

  assign acc_idle      = (st_q == AX_IDLE);
  assign bus_ack       = (st_q == AX_DONE);
  assign bus_rdata     = rd_q;
  assign crd_req_valid = (st_q == AX_ISSUE);
  assign crd_we        = we_q;
  assign crd_space     = spc_q;
  assign crd_off       = off_q;
  assign crd_size      = sz_q;
  assign crd_wdata     = wd_q;
endmodule

// File: rtl/pcwd_socket.sv
module pcwd_socket
  import pccard_win_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_idle,
  input  logic insert_req,
  input  logic eject_req,
  output logic evt_block,
  output logic occupied,
  output logic cd_irq,
  output logic crd_attach,
  output logic crd_detach,
  output logic irq_clr,
  output logic evt_done,
  output logic evt_err
);
  sock_state_e st_q, st_d;
  logic occ_q, occ_d, occ_en;
  logic cd_q, cd_d, cd_en;
  logic err_q, err_d, err_en;

  always_comb begin
    st_d   = st_q;
    occ_d  = occ_q;
    occ_en = 1'b0;
    cd_d   = cd_q;
    cd_en  = 1'b0;
    err_d  = err_q;
    err_en = 1'b0;
    case (st_q)
      SK_IDLE: begin
        if (acc_idle && insert_req) begin
          err_en = 1'b1;
          if (occ_q) begin
            err_d = 1'b1;
            st_d  = SK_DONE;
          end else begin
            err_d = 1'b0;
            cd_en = 1'b1;
            cd_d  = 1'b1;
            st_d  = SK_INS_OCC;
          end
        end else if (acc_idle && eject_req) begin
          err_en = 1'b1;
          if (!occ_q) begin
            err_d = 1'b1;
            st_d  = SK_DONE;
          end else begin
            err_d = 1'b0;
            st_d  = SK_EJ_DET;
          end
        end
      end
      SK_INS_OCC: begin
        occ_en = 1'b1;
        occ_d  = 1'b1;
        st_d   = SK_INS_ATT;
      end
      SK_INS_ATT: st_d = SK_DONE;
      SK_EJ_DET: begin
        occ_en = 1'b1;
        occ_d  = 1'b0;
        st_d   = SK_EJ_LOW;
      end
      SK_EJ_LOW: begin
        cd_en = 1'b1;
        cd_d  = 1'b0;
        st_d  = SK_DONE;
      end
      SK_DONE: st_d = SK_IDLE;
      default: st_d = SK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= 1'b0;
      cd_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (occ_en) occ_q <= occ_d;
      if (cd_en)  cd_q  <= cd_d;
      if (err_en) err_q <= err_d;
    end
  end

  assign evt_block  = (st_q != SK_IDLE) || insert_req || eject_req;
  assign occupied   = occ_q;
  assign cd_irq     = cd_q;
  assign crd_attach = (st_q == SK_INS_ATT);
  assign crd_detach = (st_q == SK_EJ_DET);
  assign irq_clr    = (st_q == SK_EJ_LOW);
  assign evt_done   = (st_q == SK_DONE);
  assign evt_err    = err_q && (st_q == SK_DONE);
endmodule

// File: rtl/pcwd_irq.sv
module pcwd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic occupied,
  input  logic host_irq_en,
  input  logic card_irq,
  input  logic irq_clr,
  output logic host_irq
);
  logic host_q, host_d, host_en;

  always_comb begin
    host_en = 1'b0;
    host_d  = host_q;
    if (irq_clr) begin
      host_en = 1'b1;
      host_d  = 1'b0;
    end else if (host_irq_en && occupied) begin
      host_en = 1'b1;
      host_d  = card_irq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_q <= 1'b0;
    else if (host_en) host_q <= host_d;
  end

  assign host_irq = host_q;
endmodule

// File: rtl/pccard_window_dec.sv
module pccard_window_dec #(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              crd_req_valid,
  input  logic              crd_req_ready,
  output logic              crd_we,
  output logic [1:0]        crd_space,
  output logic [ADDR_W-3:0] crd_off,
  output logic [1:0]        crd_size,
  output logic [DATA_W-1:0] crd_wdata,
  input  logic              crd_rsp_valid,
  input  logic [DATA_W-1:0] crd_rdata,
  output logic              crd_attach,
  output logic              crd_detach,
  input  logic              insert_req,
  input  logic              eject_req,
  output logic              evt_done,
  output logic              evt_err,
  input  logic              card_irq,
  input  logic              host_irq_en,
  output logic              host_irq,
  output logic              cd_irq,
  output logic [1:0]        sock_status
);
  logic rst_n_s, acc_idle, evt_block, occupied, irq_clr;

  pcwd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pcwd_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .occupied      (occupied),
    .evt_block     (evt_block),
    .acc_idle      (acc_idle),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_wdata     (bus_wdata),
    .bus_ack       (bus_ack),
    .bus_rdata     (bus_rdata),
    .crd_req_valid (crd_req_valid),
    .crd_req_ready (crd_req_ready),
    .crd_we        (crd_we),
    .crd_space     (crd_space),
    .crd_off       (crd_off),
    .crd_size      (crd_size),
    .crd_wdata     (crd_wdata),
    .crd_rsp_valid (crd_rsp_valid),
    .crd_rdata     (crd_rdata)
  );

  pcwd_socket u_sock (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .acc_idle   (acc_idle),
    .insert_req (insert_req),
    .eject_req  (eject_req),
    .evt_block  (evt_block),
    .occupied   (occupied),
    .cd_irq     (cd_irq),
    .crd_attach (crd_attach),
    .crd_detach (crd_detach),
    .irq_clr    (irq_clr),
    .evt_done   (evt_done),
    .evt_err    (evt_err)
  );

  pcwd_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .occupied    (occupied),
    .host_irq_en (host_irq_en),
    .card_irq    (card_irq),
    .irq_clr     (irq_clr),
    .host_irq    (host_irq)
  );

  assign sock_status = {cd_irq, occupied};
endmodule

// File: rtl/pccard_window_dec_chk.sv
module pccard_window_dec_chk #(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ack,
  input logic              crd_req_valid,
  input logic              crd_req_ready,
  input logic [1:0]        crd_space,
  input logic [ADDR_W-3:0] crd_off,
  input logic [1:0]        sock_status,
  input logic              cd_irq,
  input logic              host_irq,
  input logic              host_irq_en,
  input logic              crd_detach,
  input logic              evt_done
);
  // R3
  rsvd_never_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crd_req_valid |-> crd_space != 2'b01);

  // R4
  empty_never_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crd_req_valid |-> sock_status[0]);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_req_valid && !crd_req_ready) |=> (crd_req_valid && $stable(crd_off) && $stable(crd_space)));

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R7
  cd_before_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sock_status[0]) |-> cd_irq);

  // R8
  detach_before_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sock_status[0]) |-> $past(crd_detach));

  // R8
  cd_low_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd_irq) |-> (!sock_status[0] && !host_irq));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_irq_en && cd_irq) |=> ($stable(host_irq) || !cd_irq));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done);
endmodule

bind pccard_window_dec pccard_window_dec_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pccard_window_dec_tb.sv
`timescale 1ns/1ps
module pccard_window_dec_tb;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 32;
  localparam int NV = 8;

  // {we, addr[27:0], size[1:0], wdata[31:0], card read data[31:0]}
  localparam logic [94:0] VEC [NV] = '{
    {1'b0, 28'h0000124, 2'b10, 32'h00000000, 32'hAABB0011},
    {1'b1, 28'h3FFFFFC, 2'b00, 32'h0000005A, 32'h11111111},
    {1'b0, 28'h4000010, 2'b10, 32'h00000000, 32'hDEADBEEF},
    {1'b1, 28'h7FFFFF0, 2'b10, 32'h01020304, 32'h22222222},
    {1'b0, 28'h8000200, 2'b01, 32'h00000000, 32'h12345678},
    {1'b1, 28'hBFFFFFF, 2'b00, 32'h00000077, 32'h33333333},
    {1'b0, 28'hC000000, 2'b10, 32'h00000000, 32'hCAFEF00D},
    {1'b1, 28'hFFFFFFC, 2'b01, 32'h0000BEEF, 32'h44444444}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [1:0] bus_size;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_ack;
  logic [DATA_W-1:0] bus_rdata;
  logic crd_req_valid, crd_req_ready, crd_we;
  logic [1:0] crd_space, crd_size;
  logic [ADDR_W-3:0] crd_off;
  logic [DATA_W-1:0] crd_wdata;
  logic crd_rsp_valid;
  logic [DATA_W-1:0] crd_rdata;
  logic crd_attach, crd_detach, insert_req, eject_req, evt_done, evt_err;
  logic card_irq, host_irq_en, host_irq, cd_irq;
  logic [1:0] sock_status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pccard_window_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // captured card-side view of one access
  logic a_acked, a_fwd, a_we;
  logic [DATA_W-1:0] a_rd, a_wd;
  logic [1:0] a_space, a_size;
  logic [ADDR_W-3:0] a_off;
  int a_vcyc;

  task automatic do_access(input logic [94:0] v, input int delay);
    int hold;
    bit accepted, responded;
    hold = 0; accepted = 0; responded = 0;
    a_acked = 0; a_fwd = 0; a_vcyc = 0; a_rd = '0;
    bus_we = v[94]; bus_addr = v[93:66]; bus_size = v[65:64]; bus_wdata = v[63:32];
    bus_req = 1'b1;
    for (int c = 0; c < 40; c++) begin
      tick();
      if (bus_ack) begin
        a_acked = 1; a_rd = bus_rdata;
        bus_req = 0; crd_req_ready = 0; crd_rsp_valid = 0;
        break;
      end
      crd_rsp_valid = 0;
      if (crd_req_valid) begin
        a_fwd = 1; a_vcyc++;
        a_space = crd_space; a_off = crd_off; a_size = crd_size; a_we = crd_we; a_wd = crd_wdata;
        if (hold >= delay) crd_req_ready = 1;
        else begin crd_req_ready = 0; hold++; end
      end else begin
        if (crd_req_ready) accepted = 1;
        crd_req_ready = 0;
        if (accepted && !v[94] && !responded) begin
          crd_rsp_valid = 1; crd_rdata = v[31:0]; responded = 1;
        end
      end
    end
    bus_req = 0;
  endtask

  logic [1:0] ev_st [8];
  logic ev_att [8], ev_det [8], ev_err [8], ev_hirq [8];
  int ev_n;

  task automatic do_event(input bit ins);
    ev_n = 0;
    if (ins) insert_req = 1; else eject_req = 1;
    for (int c = 1; c < 8; c++) begin
      tick();
      ev_st[c] = sock_status; ev_att[c] = crd_attach; ev_det[c] = crd_detach;
      ev_err[c] = evt_err; ev_hirq[c] = host_irq;
      if (evt_done) begin ev_n = c; break; end
    end
    insert_req = 0; eject_req = 0;
  endtask

  task automatic run_table(input bit occ);
    for (int i = 0; i < NV; i++) begin
      logic [94:0] v;
      bit exp_fwd;
      logic [DATA_W-1:0] exp_rd;
      v = VEC[i];
      exp_fwd = occ && (v[93:92] != 2'b01);
      exp_rd = (exp_fwd && !v[94]) ? v[31:0] : '0;
      do_access(v, i % 3);
      chk(a_acked == 1'b1, "R5 ack", a_acked, 1);
      if (!occ) chk(a_fwd == 1'b0, "R4 empty no forward", a_fwd, 0);
      else if (v[93:92] == 2'b01) chk(a_fwd == 1'b0, "R3 reserved no forward", a_fwd, 0);
      else chk(a_fwd == 1'b1, "R1 forwarded", a_fwd, 1);
      chk(a_rd == exp_rd, v[93:92] == 2'b01 ? "R3 reserved rdata" : (occ ? "R5 rdata" : "R4 empty rdata"),
          a_rd, exp_rd);
      if (exp_fwd && a_fwd) begin
        chk(a_space == v[93:92], "R1 space code", a_space, v[93:92]);
        chk(a_off == v[91:66], "R2 offset", a_off, v[91:66]);
        chk(a_size == v[65:64] && a_we == v[94], "R2 size/we", {a_size, a_we}, {v[65:64], v[94]});
        if (v[94]) chk(a_wd == v[63:32], "R2 wdata", a_wd, v[63:32]);
        chk(a_vcyc == (i % 3) + 1, "R5 valid held", a_vcyc, (i % 3) + 1);
      end
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    crd_req_ready = 0; crd_rsp_valid = 0; crd_rdata = '0;
    insert_req = 0; eject_req = 0; card_irq = 0; host_irq_en = 0;
    repeat (3) tick();
    // R10 reset state
    chk(sock_status == 2'b00 && !cd_irq && !host_irq, "R10 status/irq", {sock_status, cd_irq, host_irq}, 0);
    chk(!bus_ack && !crd_req_valid && !evt_done, "R10 handshakes", {bus_ack, crd_req_valid, evt_done}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) tick();
    chk(sock_status == 2'b00, "R10 after release", sock_status, 0);

    run_table(1'b0);

    // R6 eject while empty
    do_event(1'b0);
    chk(ev_n == 1 && ev_err[1], "R6 eject empty refused", {ev_n[3:0], ev_err[1]}, 5'h03);
    chk(sock_status == 2'b00 && !ev_det[1], "R6 eject empty state", {sock_status, ev_det[1]}, 0);
    tick();

    // R7 insert sequencing
    do_event(1'b1);
    chk(ev_n == 3, "R7 insert length", ev_n, 3);
    chk(ev_st[1] == 2'b10, "R7 cd before occupied", ev_st[1], 2'b10);
    chk(ev_st[2] == 2'b11 && ev_att[2], "R7 occupied with attach", {ev_st[2], ev_att[2]}, 3'b111);
    chk(!ev_err[3] && ev_st[3] == 2'b11, "R7 done no error", {ev_err[3], ev_st[3]}, 3'b011);
    tick();

    // R6 insert while occupied
    do_event(1'b1);
    chk(ev_n == 1 && ev_err[1], "R6 insert occupied refused", {ev_n[3:0], ev_err[1]}, 5'h03);
    chk(sock_status == 2'b11 && !ev_att[1], "R6 insert occupied state", {sock_status, ev_att[1]}, 3'b110);
    tick();

    run_table(1'b1);

    // R9 host interrupt gating
    card_irq = 1; host_irq_en = 0;
    tick(); tick();
    chk(host_irq == 1'b0, "R9 ignored while disabled", host_irq, 0);
    host_irq_en = 1;
    tick();
    chk(host_irq == 1'b1, "R9 follows when enabled", host_irq, 1);
    host_irq_en = 0; card_irq = 0;
    tick(); tick();
    chk(host_irq == 1'b1, "R9 holds while disabled", host_irq, 1);
    host_irq_en = 1;
    tick();
    chk(host_irq == 1'b0, "R9 follows low", host_irq, 0);
    card_irq = 1;
    tick();
    chk(host_irq == 1'b1, "R9 follows high", host_irq, 1);

    // R8 eject sequencing
    do_event(1'b0);
    chk(ev_n == 3, "R8 eject length", ev_n, 3);
    chk(ev_det[1] && ev_st[1] == 2'b11, "R8 detach first", {ev_det[1], ev_st[1]}, 3'b111);
    chk(ev_st[2] == 2'b10 && !ev_det[2], "R8 empty before irq low", {ev_st[2], ev_det[2]}, 3'b100);
    chk(ev_st[3] == 2'b00 && !ev_hirq[3] && !ev_err[3], "R8 irqs low at done",
        {ev_st[3], ev_hirq[3], ev_err[3]}, 0);
    tick(); tick();
    chk(host_irq == 1'b0, "R9 ignored once empty", host_irq, 0);

    // R4 after eject
    do_access(VEC[6], 0);
    chk(!a_fwd && a_rd == '0, "R4 empty after eject", {a_fwd, a_rd}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule